// File: doc/BRIEF.md
# Bus-Cycle Break Condition Comparator

This block is a single watchpoint channel. It observes every cycle on a monitored bus and raises a break request when that cycle matches a programmed condition. The condition can name the bus master (processor or DMA engine), the kind of access (instruction fetch or data), the direction, and the operand size. It always includes an address compared under its own mask. When a size is selected, it also includes the data value compared under a per-bit mask.

Software programs the channel through a small register port with write strobe, index and write data. Registered read data comes back one cycle after the index is presented. A two-bit master selector of zero switches the channel off entirely. A byte-sized condition compares the data on the upper or lower byte lane of the low half-word, chosen by the parity of the bus address. The request leaves the block as a registered pulse, one clock after the matching cycle.

Top module: `bus_break_cmp`

## Requirements
- R1: After synchronous reset, every register reads as zero and `brk_pulse` is low.
- R2: Register map by `reg_idx`: 0 condition, 1 break address, 2 address mask, 3 break data, 4 data mask. Any other index reads zero and ignores writes. Condition bits are [7:6] master select, [5:4] access kind, [3:2] direction, [1:0] size.
- R3: A master select of 00 never produces a break, whatever the bus cycle.
- R4: A master select with bit 0 set matches only processor cycles (`bus_dma`=0). Master select 10 matches only DMA cycles (`bus_dma`=1).
- R5: The access-kind field is 00 for don't care, 01 for instruction fetch only (`bus_fetch`=1) and 10 for data access only. The direction field is 00 for don't care, 01 for read only and 10 for write only (`bus_wr`=1). The value 11 in either field is treated as don't care.
- R6: The address matches when, for every bit, the address-mask bit is 1 or `bus_addr` equals the break address.
- R7: The size field is 00 (no size check and no data compare), 01 (byte), 10 (word) or 11 (longword). A nonzero size matches only when `bus_size` carries the same code and the data compare holds.
- R8: A data-mask bit of 1 removes that data bit from the compare. A data-mask bit of 0 keeps it in the compare.
- R9: A byte condition compares bits 15..8 when `bus_addr[0]`=0 and bits 7..0 when `bus_addr[0]`=1. In both cases the break-data bits and the bus-data bits come from the same lane.
- R10: A word condition compares bits 15..0 and a longword condition compares all 32 bits.
- R11: `brk_pulse` is high for the clock that follows each matching cycle with `bus_valid`=1, and is low otherwise. Back-to-back matching cycles give back-to-back pulses.
- R12: The condition register keeps only bits 7..0. Bits 15..8 and above always read 0 and ignore writes.
- R13: A register write takes effect on the next cycle. A bus cycle in the same cycle as a write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the index of the previous cycle |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_dma | input | 1 | 1 = DMA master, 0 = processor |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 32 | Bus data |
| brk_pulse | output | 1 | Registered one-clock break request |

## Verification
A register write and a monitored bus cycle can occur in the same clock. In that case the comparison must use the settings from before the write. The bench provokes this by holding `reg_we` and `bus_valid` high in one cycle, once switching the channel off and once switching it on. It judges the pulse of that cycle against the old condition, and then judges the pulse of a second, identical bus cycle against the new condition.

// File: rtl/bkc_pkg.sv
package bkc_pkg;
  typedef enum logic [1:0] {SZ_ANY = 2'b00, SZ_BYTE = 2'b01, SZ_WORD = 2'b10, SZ_LONG = 2'b11} size_e;

  typedef struct packed {
    logic [1:0] master;
    logic [1:0] kind;
    logic [1:0] dir;
    size_e      size;
  } cond_t;

  localparam int IDX_W     = 3;
  localparam int IDX_COND  = 0;
  localparam int IDX_ADDR  = 1;
  localparam int IDX_AMASK = 2;
  localparam int IDX_DATA  = 3;
  localparam int IDX_DMASK = 4;
  localparam int COND_W    = $bits(cond_t);
endpackage

// File: rtl/bkc_regs.sv
module bkc_regs
  import bkc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output cond_t             cond_q,
  output logic [ADDR_W-1:0] baddr_q,
  output logic [ADDR_W-1:0] amask_q,
  output logic [DATA_W-1:0] bdata_q,
  output logic [DATA_W-1:0] dmask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q  <= '0;
      baddr_q <= '0;
      amask_q <= '0;
      bdata_q <= '0;
      dmask_q <= '0;
    end else if (we) begin
      case (idx)
        IDX_W'(IDX_COND):  cond_q  <= cond_t'(wdata[COND_W-1:0]);
        IDX_W'(IDX_ADDR):  baddr_q <= wdata[ADDR_W-1:0];
        IDX_W'(IDX_AMASK): amask_q <= wdata[ADDR_W-1:0];
        IDX_W'(IDX_DATA):  bdata_q <= wdata[DATA_W-1:0];
        IDX_W'(IDX_DMASK): dmask_q <= wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    case (idx)
      IDX_W'(IDX_COND):  rd_mux = REG_W'(cond_q);
      IDX_W'(IDX_ADDR):  rd_mux = REG_W'(baddr_q);
      IDX_W'(IDX_AMASK): rd_mux = REG_W'(amask_q);
      IDX_W'(IDX_DATA):  rd_mux = REG_W'(bdata_q);
      IDX_W'(IDX_DMASK): rd_mux = REG_W'(dmask_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // Reserved condition bits never read back as set
  assert_cond_reserved_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(idx) == IDX_W'(IDX_COND)) |-> (rdata[REG_W-1:COND_W] == '0));

  // A write to the data mask lands exactly one cycle later
  assert_dmask_update_R13: assert property (@(posedge clk) disable iff (rst)
    (we && idx == IDX_W'(IDX_DMASK)) |=> (dmask_q == $past(wdata[DATA_W-1:0])));
endmodule

// File: rtl/bkc_match.sv
module bkc_match
  import bkc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cond_t             cond,
  input  logic [ADDR_W-1:0] baddr,
  input  logic [ADDR_W-1:0] amask,
  input  logic [DATA_W-1:0] bdata,
  input  logic [DATA_W-1:0] dmask,
  input  logic              bus_dma,
  input  logic              bus_fetch,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              hit
);
  localparam logic [DATA_W-1:0] LANE_LO8  = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] LANE_HI8  = LANE_LO8 << 8;
  localparam logic [DATA_W-1:0] LANE_W16  = DATA_W'(16'hFFFF);

  logic master_ok, kind_ok, dir_ok, addr_ok, size_ok, data_ok;
  logic [DATA_W-1:0] lane, cmp_bits;

  always_comb begin
    case (cond.master)
      2'b00:   master_ok = 1'b0;
      2'b10:   master_ok = bus_dma;
      default: master_ok = !bus_dma;
    endcase
    case (cond.kind)
      2'b01:   kind_ok = bus_fetch;
      2'b10:   kind_ok = !bus_fetch;
      default: kind_ok = 1'b1;
    endcase
    case (cond.dir)
      2'b01:   dir_ok = !bus_wr;
      2'b10:   dir_ok = bus_wr;
      default: dir_ok = 1'b1;
    endcase
  end

  assign addr_ok = (((bus_addr ^ baddr) & ~amask) == '0);

  always_comb begin
    case (cond.size)
      SZ_BYTE: lane = bus_addr[0] ? LANE_LO8 : LANE_HI8;
      SZ_WORD: lane = LANE_W16;
      SZ_LONG: lane = '1;
      default: lane = '0;
    endcase
  end

  assign cmp_bits = lane & ~dmask;
  assign size_ok  = (cond.size == SZ_ANY) || (bus_size == cond.size);
  assign data_ok  = (((bus_data ^ bdata) & cmp_bits) == '0);
  assign hit      = master_ok && kind_ok && dir_ok && addr_ok && size_ok && data_ok;

  // Unmasked longword hit implies full data equality
  assert_long_data_R10: assert property (@(posedge clk) disable iff (rst)
    (hit && cond.size == SZ_LONG && dmask == '0) |-> (bus_data == bdata));

  // Masked-off address bits are the only ones allowed to differ
  assert_addr_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && amask == '0) |-> (bus_addr == baddr));
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
  import bkc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_dma,
  input  logic              bus_fetch,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              brk_pulse
);
  cond_t             cond_q;
  logic [ADDR_W-1:0] baddr_q, amask_q;
  logic [DATA_W-1:0] bdata_q, dmask_q;
  logic              hit;

  bkc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .cond_q(cond_q), .baddr_q(baddr_q), .amask_q(amask_q),
    .bdata_q(bdata_q), .dmask_q(dmask_q)
  );

  bkc_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .cond(cond_q), .baddr(baddr_q), .amask(amask_q),
    .bdata(bdata_q), .dmask(dmask_q), .bus_dma(bus_dma), .bus_fetch(bus_fetch),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_data(bus_data), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) brk_pulse <= 1'b0;
    else     brk_pulse <= bus_valid && hit;
  end

  // A pulse always follows a strobed cycle
  assert_pulse_after_valid_R11: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> $past(bus_valid));

  // Disabled channel never breaks
  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> ($past(cond_q.master) != 2'b00));

  // Master selection agrees with the master of the matched cycle
  assert_master_sel_R4: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> (($past(cond_q.master) == 2'b10) == $past(bus_dma)));
endmodule

// File: tb/bus_break_cmp_bench.sv
module bus_break_cmp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0, bus_dma = 1'b0, bus_fetch = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        brk_pulse;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_break_cmp u_bus_break_cmp (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_valid(bus_valid), .bus_dma(bus_dma),
    .bus_fetch(bus_fetch), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_data(bus_data), .brk_pulse(brk_pulse)
  );

  typedef struct packed {
    logic [7:0]  cond;
    logic [31:0] baddr, amask, bdata, dmask;
    logic        dma, fetch, wr;
    logic [1:0]  size;
    logic [31:0] addr, data;
    logic        exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h40, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b1}, // R4 cpu
    '{8'h00, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b0}, // R3 off
    '{8'h40, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b0}, // R4 dma vs cpu
    '{8'h80, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b1}, // R4 dma
    '{8'hC0, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b1}, // R4 sel 11
    '{8'h50, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b0}, // R5 fetch vs data
    '{8'h50, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b1}, // R5 fetch
    '{8'h48, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h0, 1'b0}, // R5 write vs read
    '{8'h48, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 2'b11, 32'h1000, 32'h0, 1'b1}, // R5 write
    '{8'h40, 32'h1000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1004, 32'h0, 1'b0}, // R6 miss
    '{8'h40, 32'h1000, 32'hF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1004, 32'h0, 1'b1}, // R6 masked
    '{8'h43, 32'h1000, 32'h0, 32'hDEADBEEF, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'hDEADBEEF, 1'b1}, // R10 long
    '{8'h43, 32'h1000, 32'h0, 32'hDEADBEEF, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'hDEADBEEE, 1'b0}, // R10 long miss
    '{8'h43, 32'h1000, 32'h0, 32'hDEADBEEF, 32'h1, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'hDEADBEEE, 1'b1}, // R8 mask bit
    '{8'h41, 32'h1000, 32'h0, 32'h0000AB00, 32'h0, 1'b0, 1'b0, 1'b0, 2'b01, 32'h1000, 32'h0000AB00, 1'b1}, // R9 even
    '{8'h41, 32'h1000, 32'h0, 32'h0000AB00, 32'h0, 1'b0, 1'b0, 1'b0, 2'b01, 32'h1000, 32'h000000AB, 1'b0}, // R9 wrong lane
    '{8'h41, 32'h1001, 32'h0, 32'h000000CD, 32'h0, 1'b0, 1'b0, 1'b0, 2'b01, 32'h1001, 32'hFFFF00CD, 1'b1}, // R9 odd
    '{8'h42, 32'h1000, 32'h0, 32'h12345678, 32'h0, 1'b0, 1'b0, 1'b0, 2'b10, 32'h1000, 32'hFFFF5678, 1'b1}, // R10 word
    '{8'h42, 32'h1000, 32'h0, 32'h12345678, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 32'h1000, 32'h12345678, 1'b0}, // R7 size mismatch
    '{8'h42, 32'h1000, 32'h0, 32'h12345678, 32'h0, 1'b0, 1'b0, 1'b0, 2'b10, 32'h1000, 32'h00005679, 1'b0}  // R10 word miss
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'(i); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int i, input logic [31:0] exp);
    @(negedge clk);
    reg_idx = 3'(i);
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic drive_bus(input logic dma, fetch, w, input logic [1:0] sz,
                           input logic [31:0] a, d);
    bus_valid = 1'b1; bus_dma = dma; bus_fetch = fetch; bus_wr = w;
    bus_size = sz; bus_addr = a; bus_data = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pulse", 32'(brk_pulse), 32'h0);
    for (int i = 0; i < 5; i++) rd_chk("R1 reg", i, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr(0, 32'(VECS[i].cond));
      wr(1, VECS[i].baddr);
      wr(2, VECS[i].amask);
      wr(3, VECS[i].bdata);
      wr(4, VECS[i].dmask);
      drive_bus(VECS[i].dma, VECS[i].fetch, VECS[i].wr, VECS[i].size,
                VECS[i].addr, VECS[i].data);
      @(negedge clk);
      bus_valid = 1'b0;
      chk($sformatf("vector %0d", i), 32'(brk_pulse), 32'(VECS[i].exp));
    end

    // R2 register readback and unused index
    wr(1, 32'hCAFE0001);
    rd_chk("R2 addr readback", 1, 32'hCAFE0001);
    wr(6, 32'hFFFFFFFF);
    rd_chk("R2 unused index", 6, 32'h0);

    // R12 reserved condition bits
    wr(0, 32'hFFFFFFFF);
    rd_chk("R12 cond reserved", 0, 32'h000000FF);

    // R13 write coincident with bus cycle: old settings apply
    wr(0, 32'h40); wr(1, 32'h2000); wr(2, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h0;
    drive_bus(1'b0, 1'b0, 1'b0, 2'b11, 32'h2000, 32'h0);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R13 old on", 32'(brk_pulse), 32'h1);
    @(negedge clk);
    chk("R13 new off", 32'(brk_pulse), 32'h0);
    bus_valid = 1'b0;
    @(negedge clk);
    reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h40;
    drive_bus(1'b0, 1'b0, 1'b0, 2'b11, 32'h2000, 32'h0);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R13 old off", 32'(brk_pulse), 32'h0);
    @(negedge clk);
    chk("R13 new on", 32'(brk_pulse), 32'h1);
    bus_valid = 1'b0;

    // R11 pulse timing: no pulse in strobe cycle, back-to-back, then low
    @(negedge clk);
    drive_bus(1'b0, 1'b0, 1'b0, 2'b11, 32'h2000, 32'h0);
    chk("R11 not early", 32'(brk_pulse), 32'h0);
    @(negedge clk);
    chk("R11 first", 32'(brk_pulse), 32'h1);
    @(negedge clk);
    chk("R11 second", 32'(brk_pulse), 32'h1);
    bus_valid = 1'b0;
    @(negedge clk);
    chk("R11 drop", 32'(brk_pulse), 32'h0);

    // R1 reset clears programmed state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 cond after reset", 0, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule